// File: doc/BRIEF.md
# Double-Buffered Channel Output Enable Register

This block is the 32-bit control register that a multi-channel capture/compare timer uses to switch each channel's output on or off and to set its polarity. The first channels also have a complementary output, and each of those has its own enable bit and polarity bit. On these complementary-capable channels, software writes land in a preload copy. Software reads back that copy. A separate active copy drives the output stage. The active copy follows a write at once in normal operation. When commutation preload is enabled, the active copy instead changes only when a commutation event occurs, so that every channel's output configuration switches on the same edge.

A lock-level input protects the polarity settings once the configuration has been frozen. The complementary polarity bit is protected only while its channel is set up as an output. The remaining channels have no complementary output and no preload, so their bits take effect as soon as they are written.

Top module: `chan_enable_reg`

## Requirements
- R1: Each channel `c` (counting from 0) owns bits `4c` to `4c+3`. The fields are, in order: output enable at `+0`, output polarity at `+1`, complementary enable at `+2`, complementary polarity at `+3`. Only channels 0 to 3 have the `+2` and `+3` fields, so channels 4 and 5 use only bits 16, 17, 20 and 21.
- R2: After reset, `rdData` and `activeBits` are all zero, meaning every output is inactive and active high.
- R3: While `commPreloadEn` is 1, a write to channels 0 to 3 changes `rdData` on the next cycle and leaves `activeBits` for those channels unchanged until a cycle with `commEvent` at 1. After that cycle, `activeBits` for those channels equals the preload value.
- R4: While `lockLevel` is 2 or 3, writes to any output polarity bit (`+1`) are ignored in both copies.
- R5: While `lockLevel` is 2 or 3, writes to a complementary polarity bit (`+3`) are ignored only if that channel's 2-bit mode in `chanMode[2c+1:2c]` is 00 (output). Any other mode leaves the bit writable.
- R6: Enable bits (`+0`, `+2`) stay writable at every lock level.
- R7: While `commPreloadEn` is 0, a write updates the preload copy and the active copy in the same cycle.
- R8: Channels 4 and 5 are not preloaded. A write reaches `activeBits` on the next cycle whatever the value of `commPreloadEn`.
- R9: `rdData` returns the preload copy. Bits with no field read as 0 in both outputs, and writes to them are ignored.
- R10: If a write and `commEvent` occur in the same cycle with `commPreloadEn` at 1, the preload copy takes the written value and the active copy takes the old preload value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for `wrData` |
| wrData | input | 32 | Write data |
| commPreloadEn | input | 1 | 1: active copy of channels 0 to 3 updates only on commutation |
| commEvent | input | 1 | Commutation event pulse |
| lockLevel | input | 2 | Lock level (0 to 3) |
| chanMode | input | 8 | 2-bit mode per complementary channel, 00 = output |
| rdData | output | 32 | Preload (software-visible) copy |
| activeBits | output | 32 | Active copy sent to the output stage |

## Verification
The bench builds the block with its default parameters: six channels, four of which are complementary, and a 2-bit lock level. With these values both preloaded and direct channels are present, and every lock level and every mode combination can be driven. A behavioural model compares both output copies on every cycle. It covers commutation ordering, write/commutation collisions, lock interaction with per-channel mode, and a long stretch of random traffic.

// File: rtl/chen_pkg.sv
package chen_pkg;
  localparam int FIELD_STRIDE = 4;

  typedef enum logic [1:0] {
    FLD_EN   = 2'd0,
    FLD_POL  = 2'd1,
    FLD_NEN  = 2'd2,
    FLD_NPOL = 2'd3
  } fieldSel_e;

  typedef struct packed {
    logic directLoad;  // write goes to both copies
    logic commCopy;    // move preload into active copy
  } ctlStrobe_t;
endpackage

// File: rtl/chen_ctrl.sv
module chen_ctrl
  import chen_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int NUM_COMP = 4,
  parameter int REG_W    = 32,
  parameter int LOCK_W   = 2,
  parameter int MODE_W   = 2,
  parameter int LOCK_MIN = 2
) (
  input  logic                       wrEn,
  input  logic                       commPreloadEn,
  input  logic                       commEvent,
  input  logic [LOCK_W-1:0]          lockLevel,
  input  logic [MODE_W*NUM_COMP-1:0] chanMode,
  output logic [REG_W-1:0]           wrMask,
  output ctlStrobe_t                 strobes
);
  localparam int USED_W = NUM_CH * FIELD_STRIDE;

  logic polLocked;
  assign polLocked = (int'(lockLevel) >= LOCK_MIN);

  always_comb begin
    wrMask = '0;
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int f = 0; f < FIELD_STRIDE; f++) begin
        logic present;
        logic locked;
        present = (f < 2) || (ch < NUM_COMP);
        locked  = 1'b0;
        if (f == int'(FLD_POL)) locked = polLocked;
        if (f == int'(FLD_NPOL) && ch < NUM_COMP)
          locked = polLocked && (chanMode[ch*MODE_W +: MODE_W] == '0);
        wrMask[ch*FIELD_STRIDE + f] = wrEn && present && !locked;
      end
    end
  end

  assign strobes.directLoad = wrEn && !commPreloadEn;
  assign strobes.commCopy   = commEvent;

  initial begin
    a_fit_r1: assert (USED_W <= REG_W);
  end
endmodule

// File: rtl/chen_datapath.sv
module chen_datapath
  import chen_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int NUM_COMP = 4,
  parameter int REG_W    = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [REG_W-1:0] wrData,
  input  logic [REG_W-1:0] wrMask,
  input  ctlStrobe_t       strobes,
  output logic [REG_W-1:0] preBits,
  output logic [REG_W-1:0] actBits
);
  localparam int USED_W = NUM_CH * FIELD_STRIDE;

  genvar ch, f;
  generate
    for (ch = 0; ch < NUM_CH; ch++) begin : g_ch
      for (f = 0; f < FIELD_STRIDE; f++) begin : g_fld
        localparam int B = ch * FIELD_STRIDE + f;
        if (ch < NUM_COMP) begin : g_buffered
          logic preQ, actQ;
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN) begin
              preQ <= 1'b0;
              actQ <= 1'b0;
            end else begin
              if (wrMask[B]) preQ <= wrData[B];
              if (wrMask[B] && strobes.directLoad) actQ <= wrData[B];
              else if (strobes.commCopy)           actQ <= preQ;
            end
          end
          assign preBits[B] = preQ;
          assign actBits[B] = actQ;
        end else if (f < 2) begin : g_direct
          logic bitQ;
          always_ff @(posedge clk or negedge rstN) begin
            if (!rstN)          bitQ <= 1'b0;
            else if (wrMask[B]) bitQ <= wrData[B];
          end
          assign preBits[B] = bitQ;
          assign actBits[B] = bitQ;
        end else begin : g_absent
          assign preBits[B] = 1'b0;
          assign actBits[B] = 1'b0;
        end
      end
    end
    for (ch = USED_W; ch < REG_W; ch++) begin : g_unused
      assign preBits[ch] = 1'b0;
      assign actBits[ch] = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/chan_enable_reg.sv
module chan_enable_reg
  import chen_pkg::*;
#(
  parameter int NUM_CH   = 6,
  parameter int NUM_COMP = 4,
  parameter int REG_W    = 32,
  parameter int LOCK_W   = 2,
  parameter int MODE_W   = 2
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       wrEn,
  input  logic [REG_W-1:0]           wrData,
  input  logic                       commPreloadEn,
  input  logic                       commEvent,
  input  logic [LOCK_W-1:0]          lockLevel,
  input  logic [MODE_W*NUM_COMP-1:0] chanMode,
  output logic [REG_W-1:0]           rdData,
  output logic [REG_W-1:0]           activeBits
);
  localparam int LOCK_MIN = 2;

  function automatic logic [REG_W-1:0] fieldMask(input bit compOnly, input int fld);
    logic [REG_W-1:0] m;
    m = '0;
    for (int c = 0; c < NUM_CH; c++)
      for (int f = 0; f < FIELD_STRIDE; f++)
        if ((compOnly ? (c < NUM_COMP) : 1'b1) && (fld < 0 || f == fld))
          m[c*FIELD_STRIDE + f] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] COMP_MASK = fieldMask(1'b1, -1);
  localparam logic [REG_W-1:0] POL_MASK  = fieldMask(1'b0, int'(FLD_POL));

  logic [REG_W-1:0] wrMask;
  ctlStrobe_t       strobes;

  chen_ctrl #(
    .NUM_CH(NUM_CH), .NUM_COMP(NUM_COMP), .REG_W(REG_W),
    .LOCK_W(LOCK_W), .MODE_W(MODE_W), .LOCK_MIN(LOCK_MIN)
  ) u_ctrl (
    .wrEn(wrEn), .commPreloadEn(commPreloadEn), .commEvent(commEvent),
    .lockLevel(lockLevel), .chanMode(chanMode),
    .wrMask(wrMask), .strobes(strobes)
  );

  chen_datapath #(
    .NUM_CH(NUM_CH), .NUM_COMP(NUM_COMP), .REG_W(REG_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrMask(wrMask),
    .strobes(strobes), .preBits(rdData), .actBits(activeBits)
  );

  // R4: locked output polarity bits hold in the readable copy
  p_pol_lock_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && int'(lockLevel) >= LOCK_MIN) |=> ((rdData & POL_MASK) == ($past(rdData) & POL_MASK)));

  // R3: preloaded channels hold their active bits between commutations
  p_comm_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (commPreloadEn && !commEvent) |=> ((activeBits & COMP_MASK) == ($past(activeBits) & COMP_MASK)));

  // R10: commutation loads the preload value seen before the edge
  p_comm_copy_r10: assert property (@(posedge clk) disable iff (!rstN)
    (commPreloadEn && commEvent) |=> ((activeBits & COMP_MASK) == ($past(rdData) & COMP_MASK)));

  // R7: unlocked direct write leaves both copies equal
  p_direct_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!commPreloadEn && wrEn && int'(lockLevel) < LOCK_MIN) |=> (activeBits == rdData));

  genvar gc;
  generate
    for (gc = 0; gc < NUM_COMP; gc++) begin : g_npol_chk
      // R5: complementary polarity locked for output-mode channels
      p_npol_lock_r5: assert property (@(posedge clk) disable iff (!rstN)
        (wrEn && int'(lockLevel) >= LOCK_MIN && chanMode[gc*MODE_W +: MODE_W] == '0)
          |=> $stable(rdData[gc*FIELD_STRIDE + 3]));
    end
  endgenerate
endmodule

// File: tb/sim_chan_enable_reg.sv
module sim_chan_enable_reg;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic        commPreloadEn = 1'b0;
  logic        commEvent = 1'b0;
  logic [1:0]  lockLevel = '0;
  logic [7:0]  chanMode = '0;
  logic [31:0] rdData, activeBits;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  logic [31:0] mPre = '0, mAct = '0;

  always #2 clk = ~clk;

  chan_enable_reg u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .commPreloadEn(commPreloadEn), .commEvent(commEvent),
    .lockLevel(lockLevel), .chanMode(chanMode),
    .rdData(rdData), .activeBits(activeBits)
  );

  // Behavioural next-state from current inputs
  task automatic modelStep();
    logic [31:0] nPre, nAct;
    nPre = mPre; nAct = mAct;
    for (int b = 0; b < 32; b++) begin
      int c, f;
      bit present, locked, wr;
      c = b / 4; f = b % 4;
      present = (c < 6) && (f < 2 || c < 4);
      locked = (lockLevel >= 2) &&
               (f == 1 || (f == 3 && chanMode[2*c +: 2] == 2'b00));
      wr = wrEn && present && !locked;
      if (!present) begin nPre[b] = 0; nAct[b] = 0; end
      else begin
        if (wr) nPre[b] = wrData[b];
        if (c >= 4) nAct[b] = nPre[b];
        else if (wr && !commPreloadEn) nAct[b] = wrData[b];
        else if (commEvent) nAct[b] = mPre[b];
      end
    end
    mPre = nPre; mAct = nAct;
  endtask

  task automatic compare(input string tag);
    nChecks++;
    if (rdData !== mPre || activeBits !== mAct) begin
      nFails++;
      $display("FAIL %s: rd=%h act=%h expected rd=%h act=%h", tag, rdData, activeBits, mPre, mAct);
    end
  endtask

  task automatic applyVec(input logic we, input logic [31:0] d, input logic pe,
                          input logic ce, input logic [1:0] lk, input logic [7:0] md,
                          input string tag);
    wrEn = we; wrData = d; commPreloadEn = pe; commEvent = ce;
    lockLevel = lk; chanMode = md;
    modelStep();
    @(posedge clk); @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(4 * 150000);
    nFails++;
    $display("FAIL watchdog: rd=%h act=%h expected completion", rdData, activeBits);
    if (!finished) begin
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    compare("R2 reset");
    // R1/R9: full write, direct mode, unused bits dropped
    applyVec(1, 32'hFFFF_FFFF, 0, 0, 0, 0, "R1 R9 layout");
    if (rdData !== 32'h0033_FFFF) begin nFails++; $display("FAIL R9: rd=%h expected 0033ffff", rdData); end
    nChecks++;
    applyVec(1, 32'h0, 0, 0, 0, 0, "R7 clear");
    // R3: preload only, then commutation
    applyVec(1, 32'h0000_A5C3, 1, 0, 0, 0, "R3 preload write");
    applyVec(0, 32'h0, 1, 0, 0, 0, "R3 hold");
    applyVec(0, 32'h0, 1, 1, 0, 0, "R3 commutation");
    // R10: collision
    applyVec(1, 32'h0000_3C5A, 1, 0, 0, 0, "R10 setup");
    applyVec(1, 32'h0000_FFFF, 1, 1, 0, 0, "R10 collision");
    applyVec(0, 32'h0, 1, 1, 0, 0, "R10 follow");
    // R8: channels 4/5 direct even in preload mode
    applyVec(1, 32'h0033_0000, 1, 0, 0, 0, "R8 direct");
    // R4/R6: lock level 2 blocks polarity, enables still writable
    applyVec(1, 32'h0000_0000, 0, 0, 0, 0, "R7 clear2");
    applyVec(1, 32'h0022_2222, 0, 0, 0, 0, "R4 set pol");
    applyVec(1, 32'h0011_5555, 0, 0, 2, 8'h00, "R4 R6 lock2");
    applyVec(1, 32'h0000_0000, 0, 0, 3, 8'h00, "R4 R6 lock3");
    // R5: complementary polarity with mixed modes
    applyVec(1, 32'h0000_8888, 0, 0, 0, 0, "R5 set npol");
    applyVec(1, 32'h0000_0000, 0, 0, 2, 8'b01_00_10_00, "R5 mixed modes");
    applyVec(1, 32'h0000_FFFF, 0, 0, 3, 8'b00_11_00_01, "R5 mixed modes2");
    // R9: unused-only write
    applyVec(1, 32'hFFCC_0000, 0, 0, 0, 0, "R9 unused");
    // Random traffic
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      applyVec(r[0], $urandom, r[1] | r[2], r[3] & r[4], r[6:5], r[15:8], "R3 R7 random");
    end
    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule